// File: doc/BRIEF.md
# Transceiver Transmit Width Adapter

This block sits between fabric logic and a transmit path whose internal datapath carries two bytes per internal clock. Each cycle it accepts a parallel word from the fabric and delivers one internal lane word. The lane word is either 16 raw bits or two 10-bit symbols. A width selector and an encoder-enable input set the mapping.

In the double-width settings the fabric word is twice as wide as the internal word. The block takes one fabric word every second internal cycle. It sends the lower half first and the stored upper half on the next cycle. A take strobe marks the cycles in which the fabric word is sampled, which stands in for the rising edge of the half-rate fabric clock. With the encoder on, each byte goes out together with its control-character flag. With the encoder bypassed in the 20/40 settings, each byte is widened to 10 bits by its two auxiliary bits. The block rejects the settings that are illegal with the encoder on.

Top module: `tx_width_adapter`

## Requirements
- R1: After reset, lane_o, wide_o, first_half_o and cfg_err_o are 0, and take_o is 1.
- R2: Encoder off with width_sel_i=0 (16 bits): one cycle after a take, lane_o[15:0] equals data_i[15:0] and lane_o[19:16] is 0.
- R3: Encoder off with width_sel_i=1 (20 bits): for byte lane b in {0,1}, lane_o[10b+9] is aux_mode_i[b], lane_o[10b+8] is aux_val_i[b], and lane_o[10b+7:10b] is byte b of data_i.
- R4: Encoder on with width_sel_i=1 or 3: for byte lane b, lane_o[10b+9] is 0, lane_o[10b+8] is ctrl_k_i[b], and lane_o[10b+7:10b] is the data byte.
- R5: For width_sel_i=2 (32) or 3 (40), take_o alternates 1,0 starting at 1 after reset. The cycle after a take outputs the lower half (bytes 0–1 with their aux/K bits) with first_half_o=1. The next cycle outputs the upper half (bytes 2–3) captured at the take, with first_half_o=0. Inputs presented while take_o=0 have no effect on the output.
- R6: wide_o is 1 for width_sel_i=1 or 3 and 0 for width_sel_i=0 or 2, registered with lane_o.
- R7: Encoder on with width_sel_i=0 or 2 is illegal. From the edge that samples it, cfg_err_o is 1 until reset, and lane_o, wide_o and first_half_o stay 0.
- R8: In single-width settings take_o is 1 in every cycle. A switch from a double-width setting while the upper half is pending drops that half: the current input is taken and output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Internal datapath clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| width_sel_i | input | 2 | Fabric width: 0=16, 1=20, 2=32, 3=40 |
| enc_en_i | input | 1 | Downstream line encoder enabled |
| data_i | input | 32 | Fabric data word, byte 0 at bits 7:0 |
| aux_mode_i | input | 4 | Per-byte auxiliary mode bit (encoder bypassed, 20/40) |
| aux_val_i | input | 4 | Per-byte auxiliary value bit (encoder bypassed, 20/40) |
| ctrl_k_i | input | 4 | Per-byte control-character flag (encoder on) |
| take_o | output | 1 | Fabric word sampled this cycle |
| lane_o | output | 20 | Internal lane word |
| wide_o | output | 1 | Internal width is 20 bits |
| first_half_o | output | 1 | lane_o holds the lower half of a double word |
| cfg_err_o | output | 1 | Sticky illegal-configuration flag |

## Verification
The output of a stored upper half can fall in the same cycle as the sampling of an illegal setting. The bench sets the encoder on with width 32 in the second phase of a 40-bit word. The scoreboard expects zeros and a raised error at that edge in place of the pending half. The bench also switches from width 40 to 16 while a half is pending. It then judges that the take strobe stays high and the new 16-bit word replaces the dropped half.

// File: rtl/tx_wadapt_pkg.sv
package tx_wadapt_pkg;
  typedef enum logic [1:0] {
    MODE_RAW = 2'd0,
    MODE_AUX = 2'd1,
    MODE_ENC = 2'd2
  } lane_mode_e;

  localparam int unsigned BYTE_W  = 8;
  localparam int unsigned SYM_W   = 10;
  localparam int unsigned SEL_W   = 2;
endpackage

// File: rtl/tx_wadapt_cfg.sv
module tx_wadapt_cfg
  import tx_wadapt_pkg::*;
(
  input  logic [SEL_W-1:0] width_sel_i,
  input  logic             enc_en_i,
  output lane_mode_e       mode_o,
  output logic             dbl_o,
  output logic             wide_o,
  output logic             illegal_o
);
  // sel[0]: 10-bit symbols, sel[1]: double-width fabric word
  always_comb begin
    dbl_o     = width_sel_i[1];
    wide_o    = width_sel_i[0];
    illegal_o = enc_en_i & ~width_sel_i[0];
    if (enc_en_i)            mode_o = MODE_ENC;
    else if (width_sel_i[0]) mode_o = MODE_AUX;
    else                     mode_o = MODE_RAW;
  end
endmodule

// File: rtl/tx_wadapt_phase.sv
module tx_wadapt_phase
  import tx_wadapt_pkg::*;
#(
  parameter int unsigned LANES = 2,
  localparam int unsigned HALF_W = LANES * BYTE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              dbl_i,
  input  logic [HALF_W-1:0] up_data_i,
  input  logic [LANES-1:0]  up_mode_i,
  input  logic [LANES-1:0]  up_val_i,
  input  logic [LANES-1:0]  up_k_i,
  output logic              phase_o,
  output logic [HALF_W-1:0] hold_data_o,
  output logic [LANES-1:0]  hold_mode_o,
  output logic [LANES-1:0]  hold_val_o,
  output logic [LANES-1:0]  hold_k_o
);
  logic phase_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q     <= 1'b0;
      hold_data_o <= '0;
      hold_mode_o <= '0;
      hold_val_o  <= '0;
      hold_k_o    <= '0;
    end else begin
      phase_q <= dbl_i & ~phase_q;
      if (dbl_i && !phase_q) begin
        hold_data_o <= up_data_i;
        hold_mode_o <= up_mode_i;
        hold_val_o  <= up_val_i;
        hold_k_o    <= up_k_i;
      end
    end
  end

  assign phase_o = phase_q;
endmodule

// File: rtl/tx_wadapt_lane.sv
module tx_wadapt_lane
  import tx_wadapt_pkg::*;
(
  input  lane_mode_e        mode_i,
  input  logic [BYTE_W-1:0] byte_i,
  input  logic              aux_mode_i,
  input  logic              aux_val_i,
  input  logic              ctrl_k_i,
  output logic [SYM_W-1:0]  sym_o
);
  always_comb begin
    unique case (mode_i)
      MODE_ENC: sym_o = {1'b0, ctrl_k_i, byte_i};
      MODE_AUX: sym_o = {aux_mode_i, aux_val_i, byte_i};
      default:  sym_o = {2'b00, byte_i};
    endcase
  end
endmodule

// File: rtl/tx_width_adapter.sv
module tx_width_adapter
  import tx_wadapt_pkg::*;
#(
  parameter int unsigned LANES = 2,
  localparam int unsigned HALF_W = LANES * BYTE_W,
  localparam int unsigned IN_W   = 2 * HALF_W,
  localparam int unsigned IN_B   = 2 * LANES,
  localparam int unsigned OUT_W  = LANES * SYM_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [SEL_W-1:0]   width_sel_i,
  input  logic               enc_en_i,
  input  logic [IN_W-1:0]    data_i,
  input  logic [IN_B-1:0]    aux_mode_i,
  input  logic [IN_B-1:0]    aux_val_i,
  input  logic [IN_B-1:0]    ctrl_k_i,
  output logic               take_o,
  output logic [OUT_W-1:0]   lane_o,
  output logic               wide_o,
  output logic               first_half_o,
  output logic               cfg_err_o
);
  lane_mode_e        mode;
  logic              dbl, wide, illegal, phase;
  logic [HALF_W-1:0] hold_data, cur_data;
  logic [LANES-1:0]  hold_mode, hold_val, hold_k, cur_mode, cur_val, cur_k;
  logic [OUT_W-1:0]  sym_word, next_lane;
  logic              err_q;

  tx_wadapt_cfg u_cfg (
    .width_sel_i (width_sel_i),
    .enc_en_i    (enc_en_i),
    .mode_o      (mode),
    .dbl_o       (dbl),
    .wide_o      (wide),
    .illegal_o   (illegal)
  );

  tx_wadapt_phase #(.LANES(LANES)) u_phase (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .dbl_i       (dbl),
    .up_data_i   (data_i[IN_W-1:HALF_W]),
    .up_mode_i   (aux_mode_i[IN_B-1:LANES]),
    .up_val_i    (aux_val_i[IN_B-1:LANES]),
    .up_k_i      (ctrl_k_i[IN_B-1:LANES]),
    .phase_o     (phase),
    .hold_data_o (hold_data),
    .hold_mode_o (hold_mode),
    .hold_val_o  (hold_val),
    .hold_k_o    (hold_k)
  );

  // second phase of a double word replays the captured upper half
  wire use_hold = dbl & phase;
  assign take_o = ~use_hold;

  always_comb begin
    if (use_hold) begin
      cur_data = hold_data;
      cur_mode = hold_mode;
      cur_val  = hold_val;
      cur_k    = hold_k;
    end else begin
      cur_data = data_i[HALF_W-1:0];
      cur_mode = aux_mode_i[LANES-1:0];
      cur_val  = aux_val_i[LANES-1:0];
      cur_k    = ctrl_k_i[LANES-1:0];
    end
  end

  for (genvar b = 0; b < LANES; b++) begin : g_lane
    tx_wadapt_lane u_lane (
      .mode_i     (mode),
      .byte_i     (cur_data[b*BYTE_W +: BYTE_W]),
      .aux_mode_i (cur_mode[b]),
      .aux_val_i  (cur_val[b]),
      .ctrl_k_i   (cur_k[b]),
      .sym_o      (sym_word[b*SYM_W +: SYM_W])
    );
  end

  assign next_lane = (mode == MODE_RAW) ? {{(OUT_W-HALF_W){1'b0}}, cur_data} : sym_word;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      err_q        <= 1'b0;
      lane_o       <= '0;
      wide_o       <= 1'b0;
      first_half_o <= 1'b0;
    end else if (illegal || err_q) begin
      err_q        <= 1'b1;
      lane_o       <= '0;
      wide_o       <= 1'b0;
      first_half_o <= 1'b0;
    end else begin
      lane_o       <= next_lane;
      wide_o       <= wide;
      first_half_o <= dbl & ~phase;
    end
  end

  assign cfg_err_o = err_q;
endmodule

// File: rtl/tx_width_adapter_chk.sv
module tx_width_adapter_chk
  import tx_wadapt_pkg::*;
#(
  parameter int unsigned LANES = 2,
  localparam int unsigned IN_W  = 4 * LANES * BYTE_W / 2,
  localparam int unsigned IN_B  = 2 * LANES,
  localparam int unsigned OUT_W = LANES * SYM_W
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [SEL_W-1:0] width_sel_i,
  input logic             enc_en_i,
  input logic [IN_W-1:0]  data_i,
  input logic             take_o,
  input logic [OUT_W-1:0] lane_o,
  input logic             wide_o,
  input logic             first_half_o,
  input logic             cfg_err_o
);
  // R7
  err_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_err_o |=> cfg_err_o);

  // R7
  err_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_err_o |-> (lane_o == '0 && !wide_o && !first_half_o));

  // R5
  take_alt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !take_o |=> take_o);

  // R5
  upper_half_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !take_o |=> !first_half_o);

  // R2
  raw16_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (width_sel_i == 2'd0 && !enc_en_i) |=> (lane_o[OUT_W-1:2*LANES*4] == '0 && !wide_o));

  // R4
  enc_top_bit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (enc_en_i && width_sel_i[0]) |=> (!lane_o[OUT_W-1] && !lane_o[SYM_W-1]));
endmodule

bind tx_width_adapter tx_width_adapter_chk #(.LANES(LANES)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .width_sel_i  (width_sel_i),
  .enc_en_i     (enc_en_i),
  .data_i       (data_i),
  .take_o       (take_o),
  .lane_o       (lane_o),
  .wide_o       (wide_o),
  .first_half_o (first_half_o),
  .cfg_err_o    (cfg_err_o)
);

// File: tb/tx_width_adapter_test.sv
module tx_width_adapter_test;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [1:0]  width_sel;
  logic        enc_en;
  logic [31:0] data;
  logic [3:0]  aux_m, aux_v, k;
  logic        take, wide, first, err;
  logic [19:0] lane;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  tx_width_adapter uut (
    .clk_i (clk), .rst_ni (rst_ni), .width_sel_i (width_sel), .enc_en_i (enc_en),
    .data_i (data), .aux_mode_i (aux_m), .aux_val_i (aux_v), .ctrl_k_i (k),
    .take_o (take), .lane_o (lane), .wide_o (wide), .first_half_o (first),
    .cfg_err_o (err)
  );

  logic [19:0] q_lane[$];
  logic [2:0]  q_flags[$];
  string       q_tag[$];

  logic        m_ph, m_err;
  logic [15:0] m_hd;
  logic [1:0]  m_hm, m_hv, m_hk;

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [19:0] pack(logic [15:0] d, logic [1:0] m, logic [1:0] v,
                                       logic [1:0] kk, logic enc, logic sym);
    if (!enc && !sym) return {4'h0, d};
    if (enc) return {1'b0, kk[1], d[15:8], 1'b0, kk[0], d[7:0]};
    return {m[1], v[1], d[15:8], m[0], v[0], d[7:0]};
  endfunction

  // driver: applies one cycle of stimulus and queues the expected output
  task automatic drive(logic [1:0] sel, logic e, logic [31:0] d,
                       logic [3:0] am, logic [3:0] av, logic [3:0] kk);
    logic dbl, ill;
    logic [15:0] cd;
    logic [1:0] cm, cv, ck;
    string tag;
    @(negedge clk);
    width_sel = sel; enc_en = e; data = d; aux_m = am; aux_v = av; k = kk;
    dbl = sel[1];
    ill = e && !sel[0];
    #1;
    check(dbl ? "R5 take" : "R8 take", {31'd0, take}, {31'd0, !(m_ph && dbl)});
    if (ill) m_err = 1'b1;
    if (m_err) begin
      q_lane.push_back('0);
      q_flags.push_back(3'b001);
      q_tag.push_back("R7");
    end else begin
      if (dbl && m_ph) begin
        cd = m_hd; cm = m_hm; cv = m_hv; ck = m_hk;
      end else begin
        cd = d[15:0]; cm = am[1:0]; cv = av[1:0]; ck = kk[1:0];
      end
      if (dbl) tag = "R5";
      else if (e) tag = "R4";
      else if (sel[0]) tag = "R3";
      else tag = "R2";
      q_lane.push_back(pack(cd, cm, cv, ck, e, sel[0]));
      q_flags.push_back({sel[0], dbl && !m_ph, 1'b0});
      q_tag.push_back(tag);
    end
    if (dbl && !m_ph) begin
      m_hd = d[31:16]; m_hm = am[3:2]; m_hv = av[3:2]; m_hk = kk[3:2];
    end
    m_ph = dbl ? !m_ph : 1'b0;
  endtask

  // monitor: compares registered outputs just after each edge
  always @(posedge clk) begin
    #1;
    if (q_lane.size() > 0) begin
      logic [19:0] el;
      logic [2:0]  ef;
      string t;
      el = q_lane.pop_front();
      ef = q_flags.pop_front();
      t  = q_tag.pop_front();
      check({t, " lane"}, {12'd0, lane}, {12'd0, el});
      check("R6 wide", {31'd0, wide}, {31'd0, ef[2]});
      check({t, " first_half"}, {31'd0, first}, {31'd0, ef[1]});
      check({t, " cfg_err"}, {31'd0, err}, {31'd0, ef[0]});
    end
  end

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 1'b0;
    width_sel = 2'd0; enc_en = 1'b0; data = '0; aux_m = '0; aux_v = '0; k = '0;
    m_ph = 1'b0; m_err = 1'b0; m_hd = '0; m_hm = '0; m_hv = '0; m_hk = '0;
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
    #1;
    check("R1 lane", {12'd0, lane}, 32'd0);
    check("R1 flags", {28'd0, wide, first, err, take}, 32'd1);
  endtask

  initial begin
    #(200000 * 8);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    do_reset();
    // R2 raw 16
    drive(2'd0, 0, 32'hDEAD_1234, 4'hF, 4'hF, 4'hF);
    drive(2'd0, 0, 32'h0000_FFFF, 4'h0, 4'h0, 4'h0);
    drive(2'd0, 0, 32'h5555_A5C3, 4'h3, 4'h1, 4'h2);
    // R3 bypass with aux bits
    drive(2'd1, 0, 32'h0000_81FE, 4'b0001, 4'b0010, 4'h0);
    drive(2'd1, 0, 32'h0000_3C7E, 4'b0010, 4'b0011, 4'hF);
    // R4 encoder on
    drive(2'd1, 1, 32'h0000_BC1C, 4'hF, 4'hF, 4'b0010);
    drive(2'd1, 1, 32'h0000_5A5A, 4'h0, 4'h0, 4'b0001);
    // R5 raw 32, garbage during second phase
    drive(2'd2, 0, 32'hAABB_CCDD, 4'h0, 4'h0, 4'h0);
    drive(2'd2, 0, 32'h1111_2222, 4'hF, 4'hF, 4'hF);
    drive(2'd2, 0, 32'h0123_4567, 4'h0, 4'h0, 4'h0);
    drive(2'd2, 0, 32'hFFFF_FFFF, 4'h0, 4'h0, 4'h0);
    // R5 40 bypass with aux
    drive(2'd3, 0, 32'h9876_5432, 4'b1010, 4'b0110, 4'h0);
    drive(2'd3, 0, 32'h0000_0000, 4'h0, 4'h0, 4'h0);
    // R5 40 encoder on
    drive(2'd3, 1, 32'hF7FB_BC3C, 4'h0, 4'h0, 4'b1001);
    drive(2'd3, 1, 32'h1234_5678, 4'h0, 4'h0, 4'b0110);
    // R8 switch to 16 while upper half pending
    drive(2'd3, 0, 32'hCAFE_BABE, 4'hC, 4'h3, 4'h0);
    drive(2'd0, 0, 32'h0000_7E7E, 4'h0, 4'h0, 4'h0);
    drive(2'd0, 0, 32'h0000_0101, 4'h0, 4'h0, 4'h0);
    // R7 illegal on second phase of a 40-bit word
    drive(2'd3, 0, 32'h4444_3333, 4'h5, 4'hA, 4'h0);
    drive(2'd2, 1, 32'h0000_0000, 4'h0, 4'h0, 4'h0);
    drive(2'd1, 0, 32'h0000_ABCD, 4'h3, 4'h3, 4'h0);
    drive(2'd0, 0, 32'h0000_1234, 4'h0, 4'h0, 4'h0);
    // R7 cleared by reset, R1
    do_reset();
    drive(2'd0, 1, 32'h0000_FFFF, 4'h0, 4'h0, 4'h3);
    drive(2'd3, 1, 32'h8888_9999, 4'h0, 4'h0, 4'hF);
    do_reset();
    drive(2'd0, 0, 32'h0000_00A5, 4'h0, 4'h0, 4'h0);
    drive(2'd0, 0, 32'h0000_005A, 4'h0, 4'h0, 4'h0);
    @(negedge clk);
    @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule